// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block stands between the internal clock sources of a multi-output clock generator and its output pins. All source clocks arrive as levels sampled by a fast master clock `clk`. The block picks an operating mode from a two-bit function select. It routes the right source, or a division of a test clock, to each output group. It holds individual outputs low according to enable vectors, and it takes every output down cleanly when an asynchronous active-low power-down request is held long enough.

Each output has a small gate cell. The cell accepts a new run or stop decision only while its source is low. As a result, enabling, disabling, entering power-down and leaving power-down never shorten a high phase. An interrupt-controller clock rate strap is sampled while reset is asserted. That clock then runs either at the PCI rate or at half of it. In normal modes every output follows its source with a fixed latency of two `clk` cycles.

Top module: `ckg_out_ctrl`

## Requirements
- R1: `oe_o` is 0 during reset and one cycle after `fs_i` is 2'b00; for any other `fs_i` value it is 1 one cycle later.
- R2: With `fs_i` = 2'b10, `cpu_o` follows `cpu66_i`; with 2'b11 it follows `cpu100_i`. In both modes the SDRAM, hub, PCI, USB and reference outputs follow `sdram_i`, `hub_i`, `pci_i`, `usb_i` and `ref_i`, each two `clk` cycles after the input level.
- R3: With `fs_i` = 2'b01 (test) the outputs are derived from rising edges of `tclk_i`, as follows: `ref_o` at the `tclk_i` rate; CPU, SDRAM and USB outputs at half that rate; hub at a quarter; PCI at an eighth; APIC at a sixteenth.
- R4: `strap_apic_i` is captured while `rst_n` is low and then held until the next reset. A captured 1 makes `apic_o` follow the PCI source. A captured 0 makes `apic_o` toggle once per PCI rising edge, which gives half the PCI rate. Later changes of the strap have no effect.
- R5: Enable bit mapping is as follows. `en_misc_i[0]` gates the highest CPU output. `en_misc_i[1]` and `en_misc_i[2]` gate USB outputs 0 and 1. `en_sdram_i[i]` gates SDRAM output i. `en_pci_i[i]` gates PCI output i for i >= 1. An output whose bit is 0 stays low.
- R6: `sdram_free_o`, CPU outputs 0 and 1, and PCI output 0 keep toggling whatever the enable bits are. `en_pci_i[0]` has no effect.
- R7: A change of an enable bit takes effect only while that output's source is low. No output produces a high phase shorter than its source's high phase.
- R8: Power-down starts only when `pd_n_i`, after a two-stage synchronizer, has been seen low at two rising edges of the selected CPU source. A low pulse that covers fewer edges has no effect. `osc_en_o` and `vco_en_o` fall exactly three cycles after the `pd_n_i` sample that completes qualification.
- R9: In power-down, `osc_en_o` and `vco_en_o` are 0. Each output finishes its current high phase and then stays low.
- R10: When `pd_n_i` returns high, `osc_en_o` and `vco_en_o` rise three cycles after the first high sample. Outputs resume on their next source rising edge, with full high phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_i | input | 2 | Function select: 00 tristate, 01 test, 10 low CPU rate, 11 high CPU rate |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| strap_apic_i | input | 1 | APIC rate strap, captured in reset |
| tclk_i | input | 1 | Test clock level |
| cpu66_i | input | 1 | Low-rate CPU source |
| cpu100_i | input | 1 | High-rate CPU source |
| sdram_i | input | 1 | SDRAM source |
| hub_i | input | 1 | Hub source |
| pci_i | input | 1 | PCI source |
| usb_i | input | 1 | 48 MHz source |
| ref_i | input | 1 | Reference source |
| en_misc_i | input | N_USB+1 | Enables: bit 0 top CPU, bits 1.. USB outputs |
| en_sdram_i | input | N_SDRAM | Per-output SDRAM enables |
| en_pci_i | input | N_PCI | Per-output PCI enables (bit 0 unused) |
| cpu_o | output | N_CPU | CPU clock outputs |
| sdram_o | output | N_SDRAM | Gated SDRAM outputs |
| sdram_free_o | output | 1 | Free-running SDRAM output |
| hub_o | output | N_HUB | Hub clock outputs |
| pci_o | output | N_PCI | PCI clock outputs |
| usb_o | output | N_USB | 48 MHz outputs |
| ref_o | output | 1 | Reference output |
| apic_o | output | N_APIC | Interrupt-controller clock outputs |
| oe_o | output | 1 | Output driver enable (0 = high impedance) |
| osc_en_o | output | 1 | Oscillator run enable |
| vco_en_o | output | 1 | VCO run enable |

## Verification
The hardest situations to reach from the ports are two. The first is an enable bit flipping in the middle of a high phase. The second is a power-down pulse that is too short to qualify. The bench handles the first by flipping an SDRAM enable at stepped offsets of one to three cycles over many periods, which lands changes in every phase of the source. It tracks the length of every high phase and counts any phase shorter than the source's half period. For the second, it holds the request low for three samples against a six-cycle CPU source, so at most one CPU rising edge falls in the window. It then checks that the oscillator enable never drops.

// File: rtl/ckg_pkg.sv
// Shared types for the clock output controller.
package ckg_pkg;
    // Function-select decode; the numeric values are the pin encoding.
    typedef enum logic [1:0] {
        FS_HIZ  = 2'b00,
        FS_TEST = 2'b01,
        FS_LO   = 2'b10,
        FS_HI   = 2'b11
    } ckg_mode_e;

    // One level per output group after source selection.
    typedef struct packed {
        logic cpu;
        logic sdram;
        logic hub;
        logic pci;
        logic usb;
        logic refc;
        logic apic;
    } ckg_lvl_t;
endpackage

// File: rtl/ckg_pd_qual.sv
// Power-down qualifier.
// Synchronizes the asynchronous request, then counts rising edges of the
// selected CPU level while the request is low. Asserts pd_act_o after
// QUAL_EDGES edges. Drops it as soon as the synchronized request is high.
// Assumes cpu_lvl is already registered in the clk domain.
module ckg_pd_qual #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_i,
    input  logic cpu_lvl,
    output logic pd_act_o
);
    localparam int CW = $clog2(QUAL_EDGES + 1);

    logic          s1, s2, cpu_d;
    logic [CW-1:0] cnt;
    logic          rise;

    assign rise = cpu_lvl & ~cpu_d;

    // Two-stage synchronizer for the request and a delayed CPU level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            cpu_d <= 1'b0;
        end else begin
            s1    <= pd_n_i;
            s2    <= s1;
            cpu_d <= cpu_lvl;
        end
    end

    // Edge counter that qualifies and releases power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pd_act_o <= 1'b0;
        end else if (s2) begin
            cnt      <= '0;
            pd_act_o <= 1'b0;
        end else if (rise && !pd_act_o) begin
            if (cnt == CW'(QUAL_EDGES - 1)) pd_act_o <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ckg_src_sel.sv
// Source selection and test-clock division.
// Registers every source level once. Divides the test clock with a ripple of
// counter bits, derives the half-rate APIC level from PCI rising edges, and
// picks one level per output group from the mode.
// Assumes fs_i is static during operation and that all sources are slower
// than clk/2.
module ckg_src_sel
    import ckg_pkg::*;
#(
    parameter int TDIV_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic [1:0] fs_i,
    input  logic     strap_q,
    input  logic     tclk_i,
    input  logic     cpu66_i,
    input  logic     cpu100_i,
    input  logic     sdram_i,
    input  logic     hub_i,
    input  logic     pci_i,
    input  logic     usb_i,
    input  logic     ref_i,
    output ckg_lvl_t lvl_o
);
    localparam int B_DIV2  = 0;
    localparam int B_DIV4  = 1;
    localparam int B_DIV8  = 2;
    localparam int B_DIV16 = TDIV_W - 1;

    ckg_mode_e         mode;
    logic              cpu_q, sdram_q, hub_q, pci_q, usb_q, ref_q, tclk_q;
    logic              tclk_d, pci_d, apic_t;
    logic [TDIV_W-1:0] tcnt;

    assign mode = ckg_mode_e'(fs_i);

    // Capture each source level once in the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cpu_q, sdram_q, hub_q, pci_q, usb_q, ref_q, tclk_q} <= '0;
        end else begin
            cpu_q   <= fs_i[0] ? cpu100_i : cpu66_i;
            sdram_q <= sdram_i;
            hub_q   <= hub_i;
            pci_q   <= pci_i;
            usb_q   <= usb_i;
            ref_q   <= ref_i;
            tclk_q  <= tclk_i;
        end
    end

    // Test-clock divider advanced on each test-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclk_d <= 1'b0;
            tcnt   <= '0;
        end else begin
            tclk_d <= tclk_q;
            if (tclk_q && !tclk_d) tcnt <= tcnt + 1'b1;
        end
    end

    // Half-rate APIC level toggled on each PCI rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_d  <= 1'b0;
            apic_t <= 1'b0;
        end else begin
            pci_d <= pci_q;
            if (pci_q && !pci_d) apic_t <= ~apic_t;
        end
    end

    // Per-group level selection by mode.
    always_comb begin
        lvl_o = '0;
        unique case (mode)
            FS_TEST: begin
                lvl_o.refc  = tclk_q;
                lvl_o.cpu   = tcnt[B_DIV2];
                lvl_o.sdram = tcnt[B_DIV2];
                lvl_o.usb   = tcnt[B_DIV2];
                lvl_o.hub   = tcnt[B_DIV4];
                lvl_o.pci   = tcnt[B_DIV8];
                lvl_o.apic  = tcnt[B_DIV16];
            end
            FS_LO, FS_HI: begin
                lvl_o.refc  = ref_q;
                lvl_o.cpu   = cpu_q;
                lvl_o.sdram = sdram_q;
                lvl_o.usb   = usb_q;
                lvl_o.hub   = hub_q;
                lvl_o.pci   = pci_q;
                lvl_o.apic  = strap_q ? pci_q : apic_t;
            end
            default: lvl_o = '0;
        endcase
    end
endmodule

// File: rtl/ckg_gate_bank.sv
// Bank of glitch-free output gates sharing one source level.
// Each cell latches its run decision (enable and not stopped) only while the
// source is low, so an output never loses or gains a partial high phase.
// Assumes src is a registered level in the clk domain.
module ckg_gate_bank #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src,
    input  logic         stop,
    input  logic [N-1:0] en,
    output logic [N-1:0] clk_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic run, q;

        // Update the run decision in the low phase and drive the gated level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run <= 1'b0;
                q   <= 1'b0;
            end else begin
                if (!src) run <= en[i] & ~stop;
                q <= src & run;
            end
        end

        assign clk_o[i] = q;
    end
endmodule

// File: rtl/ckg_out_ctrl.sv
// Clock output gating and power-down sequencer (top).
// Captures the APIC rate strap during reset, selects sources by mode, gates
// every output group through glitch-free cells, and sequences power-down.
// Assumes fs_i and the enables change slowly relative to the sources.
module ckg_out_ctrl
    import ckg_pkg::*;
#(
    parameter int N_CPU      = 3,
    parameter int N_SDRAM    = 8,
    parameter int N_HUB      = 2,
    parameter int N_PCI      = 8,
    parameter int N_USB      = 2,
    parameter int N_APIC     = 2,
    parameter int TDIV_W     = 4,
    parameter int QUAL_EDGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         fs_i,
    input  logic               pd_n_i,
    input  logic               strap_apic_i,
    input  logic               tclk_i,
    input  logic               cpu66_i,
    input  logic               cpu100_i,
    input  logic               sdram_i,
    input  logic               hub_i,
    input  logic               pci_i,
    input  logic               usb_i,
    input  logic               ref_i,
    input  logic [N_USB:0]     en_misc_i,
    input  logic [N_SDRAM-1:0] en_sdram_i,
    input  logic [N_PCI-1:0]   en_pci_i,
    output logic [N_CPU-1:0]   cpu_o,
    output logic [N_SDRAM-1:0] sdram_o,
    output logic               sdram_free_o,
    output logic [N_HUB-1:0]   hub_o,
    output logic [N_PCI-1:0]   pci_o,
    output logic [N_USB-1:0]   usb_o,
    output logic               ref_o,
    output logic [N_APIC-1:0]  apic_o,
    output logic               oe_o,
    output logic               osc_en_o,
    output logic               vco_en_o
);
    localparam int CPU_GATED = N_CPU - 1;

    ckg_lvl_t         lvl;
    logic             strap_q, pd_act;
    logic [N_CPU-1:0] cpu_en;
    logic [N_PCI-1:0] pci_en;

    // Strap follows its pin during reset and is frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_apic_i;
    end

    // Output driver enable from the tristate mode decode.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_o <= 1'b0;
        else        oe_o <= (ckg_mode_e'(fs_i) != FS_HIZ);
    end

    // Enable vectors for groups with fixed always-on members.
    always_comb begin
        cpu_en            = '1;
        cpu_en[CPU_GATED] = en_misc_i[0];
        pci_en            = en_pci_i;
        pci_en[0]         = 1'b1;
    end

    assign osc_en_o = ~pd_act;
    assign vco_en_o = ~pd_act;

    ckg_src_sel #(.TDIV_W(TDIV_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .strap_q(strap_q),
        .tclk_i(tclk_i), .cpu66_i(cpu66_i), .cpu100_i(cpu100_i),
        .sdram_i(sdram_i), .hub_i(hub_i), .pci_i(pci_i), .usb_i(usb_i),
        .ref_i(ref_i), .lvl_o(lvl)
    );

    ckg_pd_qual #(.QUAL_EDGES(QUAL_EDGES)) u_pd (
        .clk(clk), .rst_n(rst_n), .pd_n_i(pd_n_i), .cpu_lvl(lvl.cpu),
        .pd_act_o(pd_act)
    );

    ckg_gate_bank #(.N(N_CPU)) u_cpu (
        .clk(clk), .rst_n(rst_n), .src(lvl.cpu), .stop(pd_act),
        .en(cpu_en), .clk_o(cpu_o)
    );
    ckg_gate_bank #(.N(N_SDRAM)) u_sdram (
        .clk(clk), .rst_n(rst_n), .src(lvl.sdram), .stop(pd_act),
        .en(en_sdram_i), .clk_o(sdram_o)
    );
    ckg_gate_bank #(.N(1)) u_sdram_free (
        .clk(clk), .rst_n(rst_n), .src(lvl.sdram), .stop(pd_act),
        .en(1'b1), .clk_o(sdram_free_o)
    );
    ckg_gate_bank #(.N(N_HUB)) u_hub (
        .clk(clk), .rst_n(rst_n), .src(lvl.hub), .stop(pd_act),
        .en({N_HUB{1'b1}}), .clk_o(hub_o)
    );
    ckg_gate_bank #(.N(N_PCI)) u_pci (
        .clk(clk), .rst_n(rst_n), .src(lvl.pci), .stop(pd_act),
        .en(pci_en), .clk_o(pci_o)
    );
    ckg_gate_bank #(.N(N_USB)) u_usb (
        .clk(clk), .rst_n(rst_n), .src(lvl.usb), .stop(pd_act),
        .en(en_misc_i[N_USB:1]), .clk_o(usb_o)
    );
    ckg_gate_bank #(.N(1)) u_ref (
        .clk(clk), .rst_n(rst_n), .src(lvl.refc), .stop(pd_act),
        .en(1'b1), .clk_o(ref_o)
    );
    ckg_gate_bank #(.N(N_APIC)) u_apic (
        .clk(clk), .rst_n(rst_n), .src(lvl.apic), .stop(pd_act),
        .en({N_APIC{1'b1}}), .clk_o(apic_o)
    );
endmodule

// File: rtl/ckg_out_ctrl_chk.sv
// Property checker for the clock output controller, bound to the top.
module ckg_out_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fs_i,
    input logic       pd_n_i,
    input logic       oe_o,
    input logic       osc_en_o,
    input logic       cpu0,
    input logic       sdram0,
    input logic       en_sdram0,
    input logic       strap_q
);
    // R1
    tristate_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_i == 2'b00) |=> !oe_o);

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_sdram0) && !en_sdram0 && !sdram0) |=> !sdram0);

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en_o && !$past(osc_en_o) && !cpu0) |=> !cpu0);

    // R8
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> !$past(pd_n_i, 3));

    // R10
    pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en_o) |-> $past(pd_n_i, 3));

    // R4
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));
endmodule

bind ckg_out_ctrl ckg_out_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .pd_n_i(pd_n_i), .oe_o(oe_o),
    .osc_en_o(osc_en_o), .cpu0(cpu_o[0]), .sdram0(sdram_o[0]),
    .en_sdram0(en_sdram_i[0]), .strap_q(strap_q)
);

// File: tb/tb_ckg_out_ctrl.sv
`timescale 1ns/1ps
module tb_ckg_out_ctrl;
    localparam int P_T = 2, P_C66 = 6, P_C100 = 4, P_SD = 4, P_HUB = 6;
    localparam int P_PCI = 12, P_USB = 8, P_REF = 14;
    localparam int NS = 12;
    localparam int I_REF = 0, I_CPU = 1, I_SD = 2, I_HUB = 3, I_PCI1 = 4, I_USB0 = 5;
    localparam int I_APIC = 6, I_FREE = 7, I_PCI0 = 8, I_CPU2 = 9, I_SD7 = 10, I_USB1 = 11;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, pd_n_i, strap_apic_i, tclk_i, cpu66_i, cpu100_i;
    logic sdram_i, hub_i, pci_i, usb_i, ref_i;
    logic [1:0] fs_i;
    logic [2:0] en_misc_i;
    logic [7:0] en_sdram_i, en_pci_i;
    logic [2:0] cpu_o;
    logic [7:0] sdram_o, pci_o;
    logic [1:0] hub_o, usb_o, apic_o;
    logic sdram_free_o, ref_o, oe_o, osc_en_o, vco_en_o;

    ckg_out_ctrl dut (.*);

    int cyc = 0, total = 0, bad = 0;
    bit done = 0, trk = 0;
    int runts = 0, hi_cpu = 0, hi_sd7 = 0, hi_pci = 0, min_cpu = P_C66 / 2;
    int rc[NS];
    logic [NS-1:0] prev_s;

    function automatic bit lvl(int p, int c);
        return (c >= 0) && ((c % p) < p / 2);
    endfunction

    function automatic logic [NS-1:0] snap();
        logic [NS-1:0] s;
        s[I_REF] = ref_o;        s[I_CPU] = cpu_o[0];   s[I_SD] = sdram_o[0];
        s[I_HUB] = hub_o[0];     s[I_PCI1] = pci_o[1];  s[I_USB0] = usb_o[0];
        s[I_APIC] = apic_o[0];   s[I_FREE] = sdram_free_o; s[I_PCI0] = pci_o[0];
        s[I_CPU2] = cpu_o[2];    s[I_SD7] = sdram_o[7]; s[I_USB1] = usb_o[1];
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hi_run(input bit v, input int mn, ref int hi);
        if (v) hi++;
        else begin
            if (trk && hi > 0 && hi < mn) runts++;
            hi = 0;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        tclk_i = lvl(P_T, cyc);     cpu66_i = lvl(P_C66, cyc);
        cpu100_i = lvl(P_C100, cyc); sdram_i = lvl(P_SD, cyc);
        hub_i = lvl(P_HUB, cyc);    pci_i = lvl(P_PCI, cyc);
        usb_i = lvl(P_USB, cyc);    ref_i = lvl(P_REF, cyc);
        hi_run(cpu_o[0], min_cpu, hi_cpu);
        hi_run(sdram_o[7], P_SD / 2, hi_sd7);
        hi_run(pci_o[1], P_PCI / 2, hi_pci);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic count_rises(input int n);
        logic [NS-1:0] s;
        for (int k = 0; k < NS; k++) rc[k] = 0;
        prev_s = snap();
        for (int i = 0; i < n; i++) begin
            tick();
            s = snap();
            for (int k = 0; k < NS; k++) if (s[k] && !prev_s[k]) rc[k]++;
            prev_s = s;
        end
    endtask

    function automatic bit near(int a, int e);
        return (a >= e - 1) && (a <= e + 1);
    endfunction

    task automatic do_reset(input bit strap);
        rst_n = 1'b0; strap_apic_i = strap;
        ticks(4);
        rst_n = 1'b1;
    endtask

    initial begin
        int m_cpu, m_sd, m_hub, m_pci, m_usb, m_ref, m_apic, m_free, seen_low, any_hi;
        fs_i = 2'b11; pd_n_i = 1'b1; strap_apic_i = 1'b1;
        en_misc_i = '1; en_sdram_i = '1; en_pci_i = '1;
        rst_n = 1'b0;
        ticks(4);
        chk(oe_o == 1'b0, "R1 reset oe", oe_o, 0);
        chk(osc_en_o == 1'b1 && cpu_o == '0, "R1 reset outputs", cpu_o, 0);
        rst_n = 1'b1;
        ticks(20);
        chk(oe_o == 1'b1, "R1 oe active", oe_o, 1);

        // R2 / R4: high CPU rate, strap 1, strap pin changed after reset
        m_cpu = 0; m_sd = 0; m_hub = 0; m_pci = 0; m_usb = 0; m_ref = 0; m_apic = 0; m_free = 0;
        for (int i = 0; i < 84; i++) begin
            if (i == 3) strap_apic_i = 1'b0;
            tick();
            if (cpu_o[0] !== lvl(P_C100, cyc - 2)) m_cpu++;
            if (sdram_o[0] !== lvl(P_SD, cyc - 2)) m_sd++;
            if (hub_o[1] !== lvl(P_HUB, cyc - 2)) m_hub++;
            if (pci_o[1] !== lvl(P_PCI, cyc - 2)) m_pci++;
            if (usb_o[0] !== lvl(P_USB, cyc - 2)) m_usb++;
            if (ref_o !== lvl(P_REF, cyc - 2)) m_ref++;
            if (sdram_free_o !== lvl(P_SD, cyc - 2)) m_free++;
            if (apic_o[0] !== lvl(P_PCI, cyc - 2)) m_apic++;
        end
        chk(m_cpu == 0, "R2 cpu high rate mismatches", m_cpu, 0);
        chk(m_sd == 0, "R2 sdram mismatches", m_sd, 0);
        chk(m_hub == 0, "R2 hub mismatches", m_hub, 0);
        chk(m_pci == 0, "R2 pci mismatches", m_pci, 0);
        chk(m_usb == 0, "R2 usb mismatches", m_usb, 0);
        chk(m_ref == 0, "R2 ref mismatches", m_ref, 0);
        chk(m_free == 0, "R2 sdram_free mismatches", m_free, 0);
        chk(m_apic == 0, "R4 apic follows pci (strap 1)", m_apic, 0);

        // R2: low CPU rate
        fs_i = 2'b10;
        ticks(10);
        m_cpu = 0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (cpu_o[1] !== lvl(P_C66, cyc - 2)) m_cpu++;
        end
        chk(m_cpu == 0, "R2 cpu low rate mismatches", m_cpu, 0);

        // R1: tristate select
        fs_i = 2'b00; ticks(2);
        chk(oe_o == 1'b0, "R1 tristate oe", oe_o, 0);
        fs_i = 2'b10; ticks(2);
        chk(oe_o == 1'b1, "R1 oe restored", oe_o, 1);
        ticks(10);

        // R5 / R6: all enables cleared
        en_misc_i = '0; en_sdram_i = '0; en_pci_i = '0;
        ticks(20);
        count_rises(96);
        chk(rc[I_SD] == 0 && rc[I_SD7] == 0, "R5 sdram disabled rises", rc[I_SD] + rc[I_SD7], 0);
        chk(rc[I_CPU2] == 0, "R5 cpu2 disabled rises", rc[I_CPU2], 0);
        chk(rc[I_USB0] == 0 && rc[I_USB1] == 0, "R5 usb disabled rises", rc[I_USB0] + rc[I_USB1], 0);
        chk(rc[I_PCI1] == 0, "R5 pci1 disabled rises", rc[I_PCI1], 0);
        chk(sdram_o == '0 && pci_o[7:1] == '0, "R5 disabled outputs low", sdram_o, 0);
        chk(rc[I_FREE] == 96 / P_SD, "R6 sdram_free ignores enables", rc[I_FREE], 96 / P_SD);
        chk(rc[I_CPU] == 96 / P_C66, "R6 cpu0 ignores enables", rc[I_CPU], 96 / P_C66);
        chk(rc[I_PCI0] == 96 / P_PCI, "R6 pci0 ignores enable bit 0", rc[I_PCI0], 96 / P_PCI);
        en_misc_i = '1; en_sdram_i = '1; en_pci_i = '1;
        ticks(20);
        count_rises(96);
        chk(rc[I_SD7] == 96 / P_SD && rc[I_CPU2] == 96 / P_C66 && rc[I_USB1] == 96 / P_USB,
            "R5 re-enabled rises", rc[I_SD7], 96 / P_SD);

        // R7: enable flips at stepped phases
        runts = 0; trk = 1;
        for (int k = 0; k < 40; k++) begin
            ticks(k % 3 + 1);
            en_sdram_i[7] = ~en_sdram_i[7];
        end
        en_sdram_i[7] = 1'b1;
        ticks(12);
        chk(runts == 0, "R7 runt pulses on enable change", runts, 0);

        // R8: short request must not qualify
        seen_low = 0;
        pd_n_i = 1'b0; ticks(3); pd_n_i = 1'b1;
        for (int i = 0; i < 15; i++) begin
            tick();
            if (!osc_en_o) seen_low++;
        end
        chk(seen_low == 0, "R8 short pd pulse ignored", seen_low, 0);

        // R8 / R9: qualified power-down
        pd_n_i = 1'b0; ticks(2);
        chk(osc_en_o == 1'b1, "R8 no immediate power-down", osc_en_o, 1);
        ticks(30);
        chk(osc_en_o == 1'b0 && vco_en_o == 1'b0, "R9 osc/vco disabled", {osc_en_o, vco_en_o}, 0);
        any_hi = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (|{cpu_o, sdram_o, sdram_free_o, hub_o, pci_o, usb_o, ref_o, apic_o}) any_hi++;
        end
        chk(any_hi == 0, "R9 outputs held low", any_hi, 0);

        // R10: release
        pd_n_i = 1'b1; ticks(5);
        chk(osc_en_o == 1'b1 && vco_en_o == 1'b1, "R10 osc/vco enabled", {osc_en_o, vco_en_o}, 3);
        count_rises(48);
        chk(rc[I_CPU] == 48 / P_C66 - 1 || rc[I_CPU] == 48 / P_C66, "R10 cpu restarts", rc[I_CPU], 48 / P_C66);
        chk(rc[I_PCI1] >= 3, "R10 pci restarts", rc[I_PCI1], 4);
        chk(runts == 0, "R9 R10 runt pulses around power-down", runts, 0);
        trk = 0;

        // R3: test mode divisions
        fs_i = 2'b01; ticks(40);
        count_rises(512);
        chk(near(rc[I_REF], 256), "R3 ref = T", rc[I_REF], 256);
        chk(near(rc[I_CPU], 128), "R3 cpu = T/2", rc[I_CPU], 128);
        chk(near(rc[I_SD], 128), "R3 sdram = T/2", rc[I_SD], 128);
        chk(near(rc[I_USB0], 128), "R3 usb = T/2", rc[I_USB0], 128);
        chk(near(rc[I_HUB], 64), "R3 hub = T/4", rc[I_HUB], 64);
        chk(near(rc[I_PCI1], 32), "R3 pci = T/8", rc[I_PCI1], 32);
        chk(near(rc[I_APIC], 16), "R3 apic = T/16", rc[I_APIC], 16);

        // R4: strap 0 captured in reset, later change ignored
        fs_i = 2'b11;
        do_reset(1'b0);
        strap_apic_i = 1'b1;
        ticks(20);
        count_rises(240);
        chk(near(rc[I_PCI1], 20), "R4 pci rate", rc[I_PCI1], 20);
        chk(near(rc[I_APIC], 10), "R4 apic half pci (strap 0)", rc[I_APIC], 10);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule